// File: doc/BRIEF.md
# Short-Circuit Trip Detector with Turn-On Blanking

This block watches the digitized output of a collector-emitter desaturation comparator for one power switch and declares a short-circuit fault. Every turn-on edge of the gate command starts a programmable blanking interval. During that interval the comparator is ignored, so turn-on transients and diode recovery cannot cause a trip. Once blanking has ended, a digital deglitch filter has to see the comparator high on a programmed number of consecutive clock edges before a fault is raised.

A fault produces a single-cycle `trip_pulse`, which drives the turn-off sequencer and the latch/retry logic. It also sets `trip_sticky`, which holds until it is cleared. A combinational bound check on the configuration raises `cfg_err` when blanking plus filter length exceeds the allowed response budget. This keeps the filter from using up the short-circuit reaction time.

Top module: `sc_trip_detector`

## Requirements
- R1: After synchronous reset, `trip_pulse`, `trip_sticky` and `cfg_err` are all 0.
- R2: A turn-on edge is a clock edge at which `gate_on` is sampled 1 after being sampled 0 at the previous edge. The comparator value is ignored at that edge and at the `blank_len` edges that follow it.
- R3: If the comparator is held high, `trip_pulse` is 1 in the cycle after the (B+F)-th edge following the turn-on edge. Here B is `blank_len` and F is the effective filter length.
- R4: A `filt_len` of 0 acts as a filter length of 1, so the effective filter length F is max(`filt_len`, 1).
- R5: A comparator sample of 0 after blanking resets the consecutive-high count. A fault then needs F new consecutive high samples.
- R6: If `gate_on` falls during blanking, the detector returns to idle without a fault. While the gate is commanded off, the comparator never causes a trip.
- R7: A new turn-on edge always restarts blanking from the beginning, even if an earlier on-period was cut short.
- R8: `trip_pulse` is high for exactly one cycle, and at most once per on-period, however long the comparator stays high.
- R9: `trip_sticky` becomes 1 together with `trip_pulse` and returns to 0 one cycle after an edge with `sticky_clr` high. If a trip and a clear fall on the same edge, the trip wins.
- R10: While `en` is 0 the detector is held idle and never trips. Detection resumes at the next turn-on edge after `en` returns to 1.
- R11: `cfg_err` is 1 from the edge after `blank_len` + max(`filt_len`,1) > `resp_max` holds, and 0 from the edge after it does not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Detection enable |
| gate_on | input | 1 | Gate turn-on command |
| cmp_raw | input | 1 | Digitized desaturation comparator output |
| blank_len | input | BLANK_W | Blanking length in clock cycles |
| filt_len | input | FILT_W | Deglitch filter length in clock cycles (0 acts as 1) |
| resp_max | input | RESP_W | Maximum allowed blanking plus filter length |
| sticky_clr | input | 1 | Clears the sticky fault status |
| trip_pulse | output | 1 | One-cycle short-circuit fault pulse |
| trip_sticky | output | 1 | Sticky fault status |
| cfg_err | output | 1 | Configuration exceeds the response budget |

## Verification
Two functions can act on the same edge: the sticky-clear request, and the setting of the sticky bit by a fresh trip. The bench provokes this by asserting `sticky_clr` on exactly the edge at which the filter completes. That edge is B+F after the turn-on edge. The sticky bit must then read 1 afterwards, and a later lone clear must bring it back to 0. A second overlap is a turn-on edge that arrives while an earlier blanking interval is still running. The bench judges this by the trip latency, which must count from the newer edge.

// File: rtl/sc_pkg.sv
package sc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BLANK = 2'd1,
        ST_ARMED = 2'd2,
        ST_HOLD  = 2'd3
    } det_state_e;

    typedef struct packed {
        logic start;
        logic run;
    } blank_ctl_t;

    typedef struct packed {
        logic clear;
        logic sample;
    } filt_ctl_t;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sc_edge.sv
module sc_edge (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= 1'b0;
        end else begin
            level_q <= level;
        end
    end

    assign rise = level & ~level_q;
endmodule

// File: rtl/sc_blank_timer.sv
module sc_blank_timer
    import sc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  blank_ctl_t   ctl,
    input  logic [W-1:0] len,
    output logic         fin
);
    logic [W-1:0] cnt;
    logic [W:0]   nxt;

    assign nxt = {1'b0, cnt} + {{W{1'b0}}, 1'b1};
    // the current blanked edge is the last one when its ordinal reaches len
    assign fin = (nxt >= {1'b0, len});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (ctl.start) begin
            cnt <= '0;
        end else if (ctl.run) begin
            cnt <= nxt[W-1:0];
        end
    end
endmodule

// File: rtl/sc_glitch_filter.sv
module sc_glitch_filter
    import sc_pkg::*;
#(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  filt_ctl_t    ctl,
    input  logic         cmp,
    input  logic [W-1:0] len,
    output logic         hit
);
    logic [W-1:0] cnt;
    logic [W:0]   nxt;
    logic [W:0]   need;

    // a programmed length of zero is raised to the minimum of one sample
    assign need = (len == '0) ? {{W{1'b0}}, 1'b1} : {1'b0, len};
    assign nxt  = {1'b0, cnt} + {{W{1'b0}}, 1'b1};
    assign hit  = cmp & (nxt >= need);

    always_ff @(posedge clk) begin
        if (rst || ctl.clear) begin
            cnt <= '0;
        end else if (ctl.sample) begin
            if (cmp && !hit) begin
                cnt <= nxt[W-1:0];
            end else begin
                cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/sc_cfg_check.sv
module sc_cfg_check #(
    parameter int BW = 8,
    parameter int FW = 6,
    parameter int RW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [BW-1:0] blank_len,
    input  logic [FW-1:0] filt_len,
    input  logic [RW-1:0] resp_max,
    output logic          cfg_err
);
    logic [RW-1:0] b_ext;
    logic [RW-1:0] f_ext;
    logic [RW-1:0] total;

    assign b_ext = {{(RW-BW){1'b0}}, blank_len};
    assign f_ext = (filt_len == '0) ? {{(RW-1){1'b0}}, 1'b1} : {{(RW-FW){1'b0}}, filt_len};
    assign total = b_ext + f_ext;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_err <= 1'b0;
        end else begin
            cfg_err <= (total > resp_max);
        end
    end
endmodule

// File: rtl/sc_trip_detector.sv
module sc_trip_detector
    import sc_pkg::*;
#(
    parameter int BLANK_W = 8,
    parameter int FILT_W  = 6,
    parameter int RESP_W  = max_of(BLANK_W, FILT_W) + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               gate_on,
    input  logic               cmp_raw,
    input  logic [BLANK_W-1:0] blank_len,
    input  logic [FILT_W-1:0]  filt_len,
    input  logic [RESP_W-1:0]  resp_max,
    input  logic               sticky_clr,
    output logic               trip_pulse,
    output logic               trip_sticky,
    output logic               cfg_err
);
    det_state_e state, nstate;
    blank_ctl_t bctl;
    filt_ctl_t  fctl;
    logic       rise;
    logic       bfin;
    logic       fhit;
    logic       trip_now;

    sc_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .level(gate_on),
        .rise (rise)
    );

    sc_blank_timer #(.W(BLANK_W)) u_blank (
        .clk(clk),
        .rst(rst),
        .ctl(bctl),
        .len(blank_len),
        .fin(bfin)
    );

    sc_glitch_filter #(.W(FILT_W)) u_filt (
        .clk(clk),
        .rst(rst),
        .ctl(fctl),
        .cmp(cmp_raw),
        .len(filt_len),
        .hit(fhit)
    );

    sc_cfg_check #(.BW(BLANK_W), .FW(FILT_W), .RW(RESP_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .blank_len(blank_len),
        .filt_len (filt_len),
        .resp_max (resp_max),
        .cfg_err  (cfg_err)
    );

    always_comb begin
        nstate      = state;
        bctl        = '0;
        fctl.clear  = (state != ST_ARMED);
        fctl.sample = 1'b0;
        trip_now    = 1'b0;
        if (!en) begin
            nstate = ST_IDLE;
        end else if (rise) begin
            // every turn-on edge restarts the masking interval
            bctl.start = 1'b1;
            nstate     = (blank_len == '0) ? ST_ARMED : ST_BLANK;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    nstate = ST_IDLE;
                end
                ST_BLANK: begin
                    if (!gate_on) begin
                        nstate = ST_IDLE;
                    end else if (bfin) begin
                        nstate = ST_ARMED;
                    end else begin
                        bctl.run = 1'b1;
                    end
                end
                ST_ARMED: begin
                    if (!gate_on) begin
                        nstate = ST_IDLE;
                    end else begin
                        fctl.sample = 1'b1;
                        if (fhit) begin
                            trip_now = 1'b1;
                            nstate   = ST_HOLD;
                        end
                    end
                end
                ST_HOLD: begin
                    if (!gate_on) begin
                        nstate = ST_IDLE;
                    end
                end
                default: nstate = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            trip_pulse  <= 1'b0;
            trip_sticky <= 1'b0;
        end else begin
            state      <= nstate;
            trip_pulse <= trip_now;
            if (trip_now) begin
                trip_sticky <= 1'b1;
            end else if (sticky_clr) begin
                trip_sticky <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sc_trip_checker.sv
module sc_trip_checker #(
    parameter int BLANK_W = 8,
    parameter int FILT_W  = 6,
    parameter int RESP_W  = 9
) (
    input logic               clk,
    input logic               rst,
    input logic               en,
    input logic               gate_on,
    input logic               cmp_raw,
    input logic [BLANK_W-1:0] blank_len,
    input logic [FILT_W-1:0]  filt_len,
    input logic [RESP_W-1:0]  resp_max,
    input logic               sticky_clr,
    input logic               trip_pulse,
    input logic               trip_sticky,
    input logic               cfg_err
);
    logic        gate_seen;
    logic [15:0] since_on;
    int unsigned min_lat;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_seen <= 1'b0;
            since_on  <= '0;
        end else begin
            gate_seen <= gate_on;
            if (gate_on && !gate_seen) begin
                since_on <= '0;
            end else if (since_on != 16'hFFFF) begin
                since_on <= since_on + 16'd1;
            end
        end
    end

    always_comb begin
        min_lat = int'(blank_len) + ((filt_len == '0) ? 1 : int'(filt_len));
    end

    // R8: a fault pulse lasts one cycle
    a_r8_single_cycle: assert property (@(posedge clk) disable iff (rst)
        trip_pulse |=> !trip_pulse);

    // R9: a pulse always leaves the sticky bit set
    a_r9_sticky_follows: assert property (@(posedge clk) disable iff (rst)
        trip_pulse |-> trip_sticky);

    // R9: a clear without a concurrent trip empties the sticky bit
    a_r9_clear_takes: assert property (@(posedge clk) disable iff (rst)
        ($past(sticky_clr) && !trip_pulse) |-> !trip_sticky);

    // R3: no pulse earlier than blanking plus filter after the turn-on edge
    a_r3_min_latency: assert property (@(posedge clk) disable iff (rst)
        trip_pulse |-> (int'(since_on) >= min_lat));

    // R5 / R6 / R10: the deciding sample was high, with gate commanded on and detection enabled
    a_r6_needs_gate: assert property (@(posedge clk) disable iff (rst)
        trip_pulse |-> ($past(gate_on) && $past(en) && $past(cmp_raw)));

    // R1: outputs quiet while in reset
    always @(posedge clk) begin
        if ($past(rst)) begin
            a_r1_reset_quiet: assert (!trip_pulse && !trip_sticky && !cfg_err);
        end
    end
endmodule

bind sc_trip_detector sc_trip_checker #(
    .BLANK_W(BLANK_W),
    .FILT_W (FILT_W),
    .RESP_W (RESP_W)
) u_chk (.*);

// File: tb/sim_sc_trip_detector.sv
module sim_sc_trip_detector;
    localparam int PERIOD = 10;
    localparam int BW = 8;
    localparam int FW = 6;
    localparam int RW = 9;

    logic          clk = 1'b0;
    logic          rst;
    logic          en;
    logic          gate_on;
    logic          cmp_raw;
    logic [BW-1:0] blank_len;
    logic [FW-1:0] filt_len;
    logic [RW-1:0] resp_max;
    logic          sticky_clr;
    logic          trip_pulse;
    logic          trip_sticky;
    logic          cfg_err;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(PERIOD/2) clk = ~clk;

    sc_trip_detector #(.BLANK_W(BW), .FILT_W(FW), .RESP_W(RW)) u0 (
        .clk(clk), .rst(rst), .en(en), .gate_on(gate_on), .cmp_raw(cmp_raw),
        .blank_len(blank_len), .filt_len(filt_len), .resp_max(resp_max),
        .sticky_clr(sticky_clr), .trip_pulse(trip_pulse),
        .trip_sticky(trip_sticky), .cfg_err(cfg_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drives one on-period; edge index i samples the values set in iteration i
    task automatic run_case(input int b, input int f, input int n, input int cs, input int ce,
                            input int goff, input int gre, input int clr_i,
                            output int np, output int first);
        np = 0;
        first = -1;
        blank_len = BW'(b);
        filt_len  = FW'(f);
        for (int i = 0; i < n; i++) begin
            gate_on    = (i < goff) || (i >= gre);
            cmp_raw    = (i >= cs) && (i < ce);
            sticky_clr = (i == clr_i);
            @(negedge clk);
            if (trip_pulse) begin
                np++;
                if (first < 0) first = i;
            end
        end
        gate_on = 0; cmp_raw = 0; sticky_clr = 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (trip_pulse) np++;
        end
    endtask

    task automatic clear_sticky();
        sticky_clr = 1;
        @(negedge clk);
        sticky_clr = 0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 trip_pulse after reset", trip_pulse, 0);
        chk("R1 trip_sticky after reset", trip_sticky, 0);
        chk("R1 cfg_err after reset", cfg_err, 0);
    endtask

    task automatic t_basic();
        int np, first;
        run_case(4, 3, 20, 0, 999, 999, 9999, -1, np, first);
        chk("R3 trip edge B=4 F=3", first, 7);
        chk("R8 one pulse per on-period", np, 1);
        chk("R9 sticky set by trip", trip_sticky, 1);
        clear_sticky();
        chk("R9 sticky cleared", trip_sticky, 0);
    endtask

    task automatic t_blank_edge();
        int np, first;
        run_case(4, 1, 20, 0, 5, 999, 9999, -1, np, first);
        chk("R2 high only inside blanking ignored", np, 0);
        run_case(4, 1, 20, 0, 6, 999, 9999, -1, np, first);
        chk("R2 first sample after blanking trips", first, 5);
    endtask

    task automatic t_spike();
        int np, first;
        run_case(2, 4, 30, 3, 6, 999, 9999, -1, np, first);
        chk("R5 short burst rejected", np, 0);
        run_case(2, 4, 30, 3, 999, 999, 9999, -1, np, first);
        chk("R5 reference burst trips", first, 6);
        blank_len = BW'(2); filt_len = FW'(4);
        for (int i = 0; i < 25; i++) begin
            gate_on = 1;
            cmp_raw = (i >= 3 && i < 6) || (i >= 7);
            @(negedge clk);
            if (trip_pulse) chk("R5 count restarts after low sample", i, 10);
        end
        gate_on = 0; cmp_raw = 0;
        repeat (3) @(negedge clk);
        chk("R5 sticky after restarted count", trip_sticky, 1);
        clear_sticky();
    endtask

    task automatic t_zero_filt();
        int np, first;
        run_case(3, 0, 15, 0, 999, 999, 9999, -1, np, first);
        chk("R4 zero filter acts as one", first, 4);
        clear_sticky();
    endtask

    task automatic t_gate_off();
        int np, first;
        run_case(6, 2, 25, 0, 999, 3, 9999, -1, np, first);
        chk("R6 gate drop in blanking no trip", np, 0);
        run_case(0, 1, 15, 0, 999, 0, 9999, -1, np, first);
        chk("R6 gate off never trips", np, 0);
        chk("R6 sticky untouched", trip_sticky, 0);
    endtask

    task automatic t_rearm();
        int np, first;
        run_case(5, 2, 25, 0, 999, 3, 4, -1, np, first);
        chk("R7 blanking restarts on new edge", first, 11);
        chk("R8 single pulse after re-arm", np, 1);
        clear_sticky();
    endtask

    task automatic t_same_edge();
        int np, first;
        run_case(2, 2, 12, 0, 999, 999, 9999, 4, np, first);
        chk("R9 trip wins over clear same edge", trip_sticky, 1);
        chk("R3 trip edge B=2 F=2", first, 4);
        clear_sticky();
        chk("R9 later clear empties sticky", trip_sticky, 0);
    endtask

    task automatic t_enable();
        int np, first;
        en = 0;
        run_case(2, 1, 15, 0, 999, 999, 9999, -1, np, first);
        chk("R10 disabled no trip", np, 0);
        chk("R10 disabled sticky stays 0", trip_sticky, 0);
        en = 1;
        run_case(2, 1, 15, 0, 999, 999, 9999, -1, np, first);
        chk("R10 resumes at next turn-on", first, 3);
        clear_sticky();
    endtask

    task automatic t_cfg();
        blank_len = BW'(10); filt_len = FW'(5); resp_max = RW'(14);
        repeat (2) @(negedge clk);
        chk("R11 sum over budget", cfg_err, 1);
        resp_max = RW'(15);
        repeat (2) @(negedge clk);
        chk("R11 sum equal budget", cfg_err, 0);
        blank_len = BW'(14); filt_len = FW'(0); resp_max = RW'(14);
        repeat (2) @(negedge clk);
        chk("R11 zero filter counts one", cfg_err, 1);
        resp_max = '1;
        repeat (2) @(negedge clk);
        chk("R11 error drops", cfg_err, 0);
    endtask

    initial begin
        rst = 1; en = 1; gate_on = 0; cmp_raw = 0; sticky_clr = 0;
        blank_len = '0; filt_len = FW'(1); resp_max = '1;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_blank_edge();
        t_spike();
        t_zero_filt();
        t_gate_off();
        t_rearm();
        t_same_edge();
        t_enable();
        t_cfg();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(PERIOD * 20000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule